// File: doc/BRIEF.md
# Privileged Alignment-Flag Clear Checker

This block watches a stream of instruction bytes for one privileged instruction: the one that clears the alignment-check flag in the 32-bit flags word. Leading LOCK, operand-size and repeat prefixes are consumed first. After them the block expects the opcode bytes 0x0F, 0x01 and 0xCA in that order. Each sequence ends in one of three ways: a commit, an invalid-opcode fault, or a silent abort.

A commit clears only the alignment-check bit in the flags word sent downstream. A fault is decided from the operating mode, the privilege level, the feature-enable input and a LOCK prefix seen before the opcode. Each mode has its own set of fault rules. A silent abort covers a byte that does not match, a disallowed prefix, an early last marker, or too many bytes. It ends the sequence without a fault. In all cases the flags word is passed through with one cycle of latency. Exactly one done pulse marks the end of every sequence.

Top module: `acflag_clr_unit`

## Requirements
- R1: A sequence that ends with the bytes 0x0F, 0x01, 0xCA, with no operand-size or repeat prefix and no fault condition, commits: done_o=1 and fault_o=0 one cycle after the 0xCA byte.
- R2: If any byte 0x66, 0xF2 or 0xF3 comes before the 0x0F, a later 0x0F 0x01 0xCA ends the sequence with done_o=1, fault_o=0, and the flags passed through unchanged.
- R3: A LOCK prefix (byte 0xF0) before the opcode makes a recognized sequence fault in every mode.
- R4: A nonzero cpl_i makes a recognized sequence fault in protected (1), compatibility (3) and 64-bit (4) modes.
- R5: In real-address mode (0), cpl_i is ignored. Without LOCK and with the feature enabled, the sequence commits at any privilege level.
- R6: With feat_en_i=0, a recognized sequence faults in every mode.
- R7: In virtual-8086 mode (2), a recognized sequence always faults.
- R8: flags_o equals flags_i from the previous cycle. On a commit, bit 18 (the alignment-check flag) is 0 in that cycle, and no other bit differs.
- R9: A byte that breaks the 0x0F, 0x01, 0xCA order ends the sequence with done_o=1 and fault_o=0. That byte is discarded.
- R10: When the 15th byte of a sequence does not complete the opcode, the sequence ends with done_o=1 and fault_o=0. A 0xCA arriving as the 15th byte still completes the opcode.
- R11: A byte with byte_last=1 that does not complete the opcode ends the sequence with done_o=1 and fault_o=0.
- R12: done_o pulses for one cycle, exactly one cycle after the byte that ends a sequence. fault_o is only ever 1 together with done_o. A cycle with byte_vld=0 produces no done_o in the next cycle.
- R13: Mode codes 5, 6 and 7 are reserved. A recognized sequence faults under any of them.
- R14: While rst is high, and in the cycle after it, flags_o, fault_o and done_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | Instruction byte is present this cycle |
| byte_data | input | 8 | Instruction byte |
| byte_last | input | 1 | Final byte of the instruction |
| mode_i | input | 3 | Operating mode: 0 real, 1 protected, 2 virtual-8086, 3 compatibility, 4 64-bit |
| cpl_i | input | 2 | Current privilege level |
| feat_en_i | input | 1 | Feature enable for the instruction |
| flags_i | input | 32 | Current flags word |
| flags_o | output | 32 | Flags word one cycle later, alignment-check bit cleared on commit |
| fault_o | output | 1 | Invalid-opcode fault, valid together with done_o |
| done_o | output | 1 | Sequence finished |

## Verification
The assertions assume that mode_i, cpl_i and feat_en_i are stable and meaningful in the cycle that carries the completing 0xCA byte. The fault is decided from the values in that cycle alone. The assertions also assume byte_data is only read while byte_vld is high. The stimulus changes mode, privilege and feature bit only between sequences. It drives random bytes with byte_vld low during gaps, and varies flags_i on every cycle, so the pass-through of R8 is exercised continuously and not only on completing bytes.

// File: rtl/acclr_pkg.sv
package acclr_pkg;

  typedef enum logic [2:0] {
    MODE_REAL   = 3'd0,
    MODE_PROT   = 3'd1,
    MODE_V86    = 3'd2,
    MODE_COMPAT = 3'd3,
    MODE_LONG   = 3'd4
  } cpu_mode_e;

  typedef enum logic [1:0] {
    SC_PREFIX = 2'd0,
    SC_ESC    = 2'd1,
    SC_GRP    = 2'd2
  } scan_st_e;

  localparam logic [7:0] OPC_ESC   = 8'h0F;
  localparam logic [7:0] OPC_GRP   = 8'h01;
  localparam logic [7:0] OPC_TAIL  = 8'hCA;
  localparam logic [7:0] PFX_LOCK  = 8'hF0;
  localparam logic [7:0] PFX_OPSZ  = 8'h66;
  localparam logic [7:0] PFX_REPNE = 8'hF2;
  localparam logic [7:0] PFX_REP   = 8'hF3;

  // modes in which LOCK faults / privilege level is checked (bit index = mode code)
  localparam logic [7:0] LOCK_CHK_MODES = 8'b0001_1011;
  localparam logic [7:0] CPL_CHK_MODES  = 8'b0001_1010;
  localparam int unsigned MODE_LAST     = 4;

  function automatic logic is_bad_prefix(input logic [7:0] b);
    return (b == PFX_OPSZ) || (b == PFX_REPNE) || (b == PFX_REP);
  endfunction

endpackage

// File: rtl/acclr_seq_scan.sv
module acclr_seq_scan
  import acclr_pkg::*;
#(
  parameter int unsigned MAX_LEN = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vld,
  input  logic [7:0] data,
  input  logic       last,
  output logic       seq_end_o,
  output logic       seq_hit_o,
  output logic       lock_o
);

  localparam int unsigned CNT_W = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(MAX_LEN);

  scan_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             lock_q, bad_q;
  logic             is_lock, is_bad, full, miss;

  assign is_lock = (data == PFX_LOCK);
  assign is_bad  = is_bad_prefix(data);
  assign cnt_nx  = cnt_q + CNT_W'(1);

  always_comb begin
    st_d = st_q;
    full = 1'b0;
    miss = 1'b0;
    unique case (st_q)
      SC_PREFIX: begin
        if (data == OPC_ESC)          st_d = SC_ESC;
        else if (!(is_lock || is_bad)) miss = 1'b1;
      end
      SC_ESC: begin
        if (data == OPC_GRP) st_d = SC_GRP;
        else                 miss = 1'b1;
      end
      SC_GRP: begin
        if (data == OPC_TAIL) full = 1'b1;
        else                  miss = 1'b1;
      end
      default: miss = 1'b1;
    endcase
  end

  assign seq_end_o = vld && (full || miss || last || (cnt_nx == CNT_CAP));
  assign seq_hit_o = vld && full && !bad_q;
  assign lock_o    = lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SC_PREFIX;
      cnt_q  <= '0;
      lock_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (vld) begin
      if (seq_end_o) begin
        st_q   <= SC_PREFIX;
        cnt_q  <= '0;
        lock_q <= 1'b0;
        bad_q  <= 1'b0;
      end else begin
        st_q   <= st_d;
        cnt_q  <= cnt_nx;
        lock_q <= lock_q || (st_q == SC_PREFIX && is_lock);
        bad_q  <= bad_q  || (st_q == SC_PREFIX && is_bad);
      end
    end
  end

endmodule

// File: rtl/acclr_fault_eval.sv
module acclr_fault_eval
  import acclr_pkg::*;
(
  input  logic [2:0] mode,
  input  logic [1:0] cpl,
  input  logic       feat_en,
  input  logic       lock,
  output logic       fault_o
);

  logic mode_ok, lock_flt, cpl_flt, v86_flt;

  always_comb begin
    mode_ok  = (32'(mode) <= MODE_LAST);
    v86_flt  = (mode == MODE_V86);
    lock_flt = lock && LOCK_CHK_MODES[mode];
    cpl_flt  = (cpl != 2'd0) && CPL_CHK_MODES[mode];
    fault_o  = !feat_en || !mode_ok || v86_flt || lock_flt || cpl_flt;
  end

endmodule

// File: rtl/acclr_flag_commit.sv
module acclr_flag_commit #(
  parameter int unsigned FLAG_W = 32,
  parameter int unsigned AC_BIT = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              seq_end,
  input  logic              seq_hit,
  input  logic              fault,
  output logic [FLAG_W-1:0] flags_o,
  output logic              fault_o,
  output logic              done_o
);

  localparam logic [FLAG_W-1:0] AC_MASK = {{(FLAG_W-1){1'b0}}, 1'b1} << AC_BIT;

  logic commit;
  assign commit = seq_hit && !fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o <= '0;
      fault_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      flags_o <= commit ? (flags_i & ~AC_MASK) : flags_i;
      fault_o <= seq_hit && fault;
      done_o  <= seq_end;
    end
  end

endmodule

// File: rtl/acflag_clr_unit.sv
module acflag_clr_unit
  import acclr_pkg::*;
#(
  parameter int unsigned FLAG_W  = 32,
  parameter int unsigned AC_BIT  = 18,
  parameter int unsigned MAX_LEN = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              byte_last,
  input  logic [2:0]        mode_i,
  input  logic [1:0]        cpl_i,
  input  logic              feat_en_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              fault_o,
  output logic              done_o
);

  logic seq_end, seq_hit, lock_seen, flt;

  acclr_seq_scan #(.MAX_LEN(MAX_LEN)) scan_i (
    .clk       (clk),
    .rst       (rst),
    .vld       (byte_vld),
    .data      (byte_data),
    .last      (byte_last),
    .seq_end_o (seq_end),
    .seq_hit_o (seq_hit),
    .lock_o    (lock_seen)
  );

  acclr_fault_eval eval_i (
    .mode    (mode_i),
    .cpl     (cpl_i),
    .feat_en (feat_en_i),
    .lock    (lock_seen),
    .fault_o (flt)
  );

  acclr_flag_commit #(.FLAG_W(FLAG_W), .AC_BIT(AC_BIT)) commit_i (
    .clk     (clk),
    .rst     (rst),
    .flags_i (flags_i),
    .seq_end (seq_end),
    .seq_hit (seq_hit),
    .fault   (flt),
    .flags_o (flags_o),
    .fault_o (fault_o),
    .done_o  (done_o)
  );

endmodule

// File: rtl/acclr_chk.sv
module acclr_chk
  import acclr_pkg::*;
#(
  parameter int unsigned FLAG_W  = 32,
  parameter int unsigned AC_BIT  = 18,
  parameter int unsigned MAX_LEN = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              byte_vld,
  input logic [2:0]        mode_i,
  input logic [1:0]        cpl_i,
  input logic              feat_en_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic [FLAG_W-1:0] flags_o,
  input logic              fault_o,
  input logic              done_o,
  input logic              seq_end,
  input logic              seq_hit,
  input logic              lock_seen
);

  localparam int unsigned CW = $clog2(MAX_LEN + 1);
  localparam logic [FLAG_W-1:0] AC_MASK = {{(FLAG_W-1){1'b0}}, 1'b1} << AC_BIT;

  logic [CW-1:0]     len_q;
  logic [FLAG_W-1:0] flags_d;
  logic              armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (byte_vld) len_q <= seq_end ? '0 : len_q + CW'(1);
    end
    flags_d <= flags_i;
  end

  p_hit_commit_r1: assert property (@(posedge clk) disable iff (rst)
    (seq_hit && feat_en_i && mode_i == MODE_PROT && cpl_i == 2'd0 && !lock_seen)
      |=> (done_o && !fault_o && !flags_o[AC_BIT]));

  p_lock_fault_r3: assert property (@(posedge clk) disable iff (rst)
    (seq_hit && lock_seen) |=> fault_o);

  p_cpl_fault_r4: assert property (@(posedge clk) disable iff (rst)
    (seq_hit && cpl_i != 2'd0 &&
     (mode_i == MODE_PROT || mode_i == MODE_COMPAT || mode_i == MODE_LONG)) |=> fault_o);

  p_real_cpl_free_r5: assert property (@(posedge clk) disable iff (rst)
    (seq_hit && mode_i == MODE_REAL && feat_en_i && !lock_seen)
      |=> (!fault_o && !flags_o[AC_BIT]));

  p_feat_off_r6: assert property (@(posedge clk) disable iff (rst)
    (seq_hit && !feat_en_i) |=> (fault_o && flags_o[AC_BIT] == $past(flags_i[AC_BIT])));

  p_v86_fault_r7: assert property (@(posedge clk) disable iff (rst)
    (seq_hit && mode_i == MODE_V86) |=> fault_o);

  p_flags_track_r8: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (((flags_o ^ flags_d) & ~AC_MASK) == '0));

  p_abort_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (seq_end && !seq_hit) |=> (done_o && !fault_o));

  p_len_cap_r10: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && 32'(len_q) == MAX_LEN - 1) |-> seq_end);

  p_fault_with_done_r12: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> done_o);

  p_idle_no_done_r12: assert property (@(posedge clk) disable iff (rst)
    !byte_vld |=> !done_o);

  p_reserved_mode_r13: assert property (@(posedge clk) disable iff (rst)
    (seq_hit && 32'(mode_i) > MODE_LAST) |=> fault_o);

endmodule

bind acflag_clr_unit acclr_chk #(.FLAG_W(FLAG_W), .AC_BIT(AC_BIT), .MAX_LEN(MAX_LEN)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .byte_vld  (byte_vld),
  .mode_i    (mode_i),
  .cpl_i     (cpl_i),
  .feat_en_i (feat_en_i),
  .flags_i   (flags_i),
  .flags_o   (flags_o),
  .fault_o   (fault_o),
  .done_o    (done_o),
  .seq_end   (seq_end),
  .seq_hit   (seq_hit),
  .lock_seen (lock_seen)
);

// File: tb/acflag_clr_unit_tb_top.sv
module acflag_clr_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAXB       = 15;
  localparam int ACB        = 18;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic        byte_last = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic [1:0]  cpl_i = 2'd0;
  logic        feat_en_i = 1'b1;
  logic [31:0] flags_i = 32'h0;
  logic [31:0] flags_o;
  logic        fault_o, done_o;

  acflag_clr_unit dut_i (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
    .byte_last(byte_last), .mode_i(mode_i), .cpl_i(cpl_i), .feat_en_i(feat_en_i),
    .flags_i(flags_i), .flags_o(flags_o), .fault_o(fault_o), .done_o(done_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    n_checks = 0;
  int    n_fails  = 0;
  int    cyc      = 0;
  string cur_tag  = "R14 reset";

  // ---------------- reference model ----------------
  logic [7:0]  mq[$];
  logic [31:0] exp_flags = 0;
  logic        exp_fault = 0, exp_done = 0;
  bit          model_live = 0;

  // 0 = keep collecting, 1 = end without fault, 2 = recognized
  function automatic int classify(input bit last, output bit lock_seen);
    int  i    = 0;
    bit  bad  = 0;
    bit  mism = 0;
    int  rest;
    lock_seen = 0;
    while (i < mq.size() && (mq[i] == 8'hF0 || mq[i] == 8'h66 ||
                             mq[i] == 8'hF2 || mq[i] == 8'hF3)) begin
      if (mq[i] == 8'hF0) lock_seen = 1;
      else                bad = 1;
      i++;
    end
    rest = mq.size() - i;
    for (int j = 0; j < rest; j++) begin
      logic [7:0] want;
      want = (j == 0) ? 8'h0F : (j == 1) ? 8'h01 : 8'hCA;
      if (mq[i + j] != want) mism = 1;
    end
    if (!mism && rest == 3) return bad ? 1 : 2;
    if (mism || last || mq.size() >= MAXB) return 1;
    return 0;
  endfunction

  function automatic bit model_fault(input bit lock);
    if (!feat_en_i) return 1;
    case (mode_i)
      3'd0:             return lock;
      3'd1, 3'd3, 3'd4: return lock || (cpl_i != 2'd0);
      default:          return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mq.delete();
      exp_flags = 0; exp_fault = 0; exp_done = 0;
    end else begin
      int r;
      bit lk;
      bit f;
      exp_flags = flags_i;
      exp_fault = 0;
      exp_done  = 0;
      if (byte_vld) begin
        mq.push_back(byte_data);
        r = classify(byte_last, lk);
        if (r != 0) begin
          exp_done = 1;
          if (r == 2) begin
            f = model_fault(lk);
            exp_fault = f;
            if (!f) exp_flags[ACB] = 1'b0;
          end
          mq.delete();
        end
      end
    end
    model_live = 1;
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (model_live) begin
      n_checks++;
      if (flags_o !== exp_flags || fault_o !== exp_fault || done_o !== exp_done) begin
        n_fails++;
        $display("FAIL %s: actual flags=%h fault=%b done=%b expected flags=%h fault=%b done=%b",
                 cur_tag, flags_o, fault_o, done_o, exp_flags, exp_fault, exp_done);
      end
    end
  end

  // flags_i moves every cycle; bit 18 mostly set so a clear is visible
  always @(negedge clk) flags_i <= $urandom() | (($urandom() % 4 != 0) ? (32'h1 << ACB) : 32'h0);

  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      n_checks++; n_fails++;
      $display("FAIL R12 watchdog: actual running at cycle %0d expected end before %0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  logic [7:0] sq[$];

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      byte_vld = 0; byte_last = 0; byte_data = $urandom();
    end
  endtask

  task automatic play(input logic [2:0] m, input logic [1:0] c, input bit fe,
                      input bit mark_last, input bit gaps, input string tag);
    @(negedge clk);
    cur_tag = tag; mode_i = m; cpl_i = c; feat_en_i = fe;
    for (int k = 0; k < sq.size(); k++) begin
      if (gaps && ($urandom() % 2)) idle(1 + $urandom() % 2);
      if (k != 0 || gaps) @(negedge clk);
      byte_vld  = 1;
      byte_data = sq[k];
      byte_last = mark_last && (k == sq.size() - 1);
    end
    idle(2);
  endtask

  task automatic opc(input int n_pfx, input logic [7:0] pfx);
    sq.delete();
    for (int k = 0; k < n_pfx; k++) sq.push_back(pfx);
    sq.push_back(8'h0F); sq.push_back(8'h01); sq.push_back(8'hCA);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    n_checks++;
    if (flags_o !== 0 || fault_o !== 0 || done_o !== 0) begin
      n_fails++;
      $display("FAIL R14: actual flags=%h fault=%b done=%b expected all zero", flags_o, fault_o, done_o);
    end
    rst = 0;
    idle(3);

    // R1 / R8: clean commit in the modes that allow it
    foreach (sq[k]) ;
    for (int m = 0; m <= 4; m++) begin
      if (m == 2) continue;
      opc(0, 8'h00); play(3'(m), 2'd0, 1, 1, 0, "R1 R8 commit");
    end
    opc(0, 8'h00); play(3'd4, 2'd0, 1, 0, 1, "R1 R12 commit with gaps");
    // R2: disallowed prefixes
    opc(1, 8'h66); play(3'd1, 2'd0, 1, 1, 0, "R2 opsize prefix");
    opc(2, 8'hF2); play(3'd4, 2'd0, 1, 1, 0, "R2 repne prefix");
    opc(1, 8'hF3); play(3'd0, 2'd0, 1, 0, 0, "R2 rep prefix");
    // R3: LOCK
    for (int m = 0; m <= 4; m++) begin
      opc(1, 8'hF0); play(3'(m), 2'd0, 1, 1, 0, "R3 lock fault");
    end
    // R4 / R5: privilege
    for (int c = 1; c <= 3; c++) begin
      opc(0, 8'h00); play(3'd1, 2'(c), 1, 1, 0, "R4 cpl protected");
      opc(0, 8'h00); play(3'd3, 2'(c), 1, 1, 0, "R4 cpl compat");
      opc(0, 8'h00); play(3'd4, 2'(c), 1, 1, 0, "R4 cpl 64-bit");
      opc(0, 8'h00); play(3'd0, 2'(c), 1, 1, 0, "R5 real ignores cpl");
    end
    // R6 feature off, R7 v86, R13 reserved modes
    for (int m = 0; m <= 7; m++) begin
      opc(0, 8'h00); play(3'(m), 2'd0, 0, 1, 0, "R6 feature off");
    end
    opc(0, 8'h00); play(3'd2, 2'd0, 1, 1, 0, "R7 v86 fault");
    opc(0, 8'h00); play(3'd2, 2'd3, 1, 0, 1, "R7 v86 fault cpl3");
    for (int m = 5; m <= 7; m++) begin
      opc(0, 8'h00); play(3'(m), 2'd0, 1, 1, 0, "R13 reserved mode");
    end
    // R9 mismatches
    sq = '{8'h0F, 8'h02};        play(3'd1, 2'd0, 1, 0, 0, "R9 bad second byte");
    sq = '{8'h0F, 8'h01, 8'hCB}; play(3'd1, 2'd0, 1, 0, 0, "R9 bad third byte");
    sq = '{8'h90};               play(3'd1, 2'd0, 1, 0, 0, "R9 bad first byte");
    sq = '{8'h0F, 8'hF0, 8'h0F, 8'h01, 8'hCA}; play(3'd1, 2'd0, 1, 0, 0, "R9 prefix after escape");
    // R10 length cap
    sq.delete(); for (int k = 0; k < 15; k++) sq.push_back(8'hF0);
    play(3'd1, 2'd0, 1, 0, 0, "R10 fifteen prefixes");
    opc(13, 8'hF0); play(3'd1, 2'd0, 1, 0, 0, "R10 cut before tail");
    opc(12, 8'hF0); play(3'd0, 2'd0, 1, 0, 0, "R10 tail as 15th byte");
    opc(12, 8'h66); play(3'd1, 2'd0, 1, 0, 1, "R10 R2 long bad prefix");
    // R11 early last
    sq = '{8'h0F, 8'h01};        play(3'd1, 2'd0, 1, 1, 0, "R11 early last");
    sq = '{8'hF0};               play(3'd4, 2'd0, 1, 1, 0, "R11 last on prefix");

    // R12 random streams, settings held per sequence
    for (int s = 0; s < 400; s++) begin
      logic [7:0] pool [8] = '{8'h0F, 8'h01, 8'hCA, 8'hF0, 8'h66, 8'hF3, 8'h0F, 8'h00};
      int len = 1 + $urandom() % 6;
      sq.delete();
      if ($urandom() % 2) begin
        opc($urandom() % 3, pool[3 + $urandom() % 3]);
      end else begin
        for (int k = 0; k < len; k++) sq.push_back(pool[$urandom() % 8]);
      end
      play(3'($urandom() % 8), 2'($urandom()), ($urandom() % 4) != 0,
           $urandom() % 2, $urandom() % 2, "R12 random stream");
    end

    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule